// File: doc/BRIEF.md
# Cache hit/miss monitor unit

This unit sits next to an instruction cache and collects statistics on how well the cache serves its requester. The cache gives it one pulse per finished input transaction. A hit pulse means the transaction was served without starting any transaction on a downstream master port. That includes data taken from the tag array and data taken from the refill buffer while a line is still filling. A miss pulse means a downstream transaction was started. The unit counts hits in a wide counter and misses in a narrower one. Software can enable and clear each counter separately. Both counters are off after reset, and each stops at its maximum value rather than wrapping.

The unit also holds two sticky status flags. One records that the cache detected a cacheable write it cannot support. The other records that an invalidation sequence has finished. Each flag has its own interrupt enable, and the single interrupt output combines the enabled flags. A small register bus gives access to the control bits, the flags, a flag-clear register and both counters. Reads are combinational on the address and writes take effect at the clock edge.

Top module: `cache_mon`

## Requirements
- R1: While the hit enable is set, each clock cycle with `ev_hit` high increments the hit counter by one. The hit counter is HIT_W bits wide, 32 by default.
- R2: While the miss enable is set, each clock cycle with `ev_miss` high increments the miss counter by one. The miss counter is MISS_W bits wide, 16 by default. The miss counter is independent of the hit counter, so a cycle with both pulses high advances both enabled counters.
- R3: After a synchronous reset:
  - both enables and both interrupt enables are 0;
  - both counters are 0;
  - both flags are 0;
  - `irq` is 0.
- R4: A counter that holds its all-ones maximum stays at that value on further counted events. It never wraps.
- R5: Writing 1 to a counter's clear bit sets that counter to 0 at the same edge. The clear wins over an increment in that same cycle. The clear bits are self-clearing, read back as 0, and do not change the enables.
- R6: While a counter's enable is 0, that counter keeps its value whatever its event input does.
- R7: A high `ev_wr_err` sets the error flag, and the flag stays set until software writes 1 to bit 0 of the flag-clear register. If a set and a clear happen in the same cycle, the flag ends set.
- R8: A high `ev_inval_done` sets the end flag, and the flag stays set until software writes 1 to bit 1 of the flag-clear register. If a set and a clear happen in the same cycle, the flag ends set. Clearing one flag leaves the other unchanged.
- R9: `irq` is high exactly when (error flag AND error interrupt enable) OR (end flag AND end interrupt enable) is true, computed from the registered flags and enables.
- R10: Register map on `bus_addr`:
  - Offset 0 is control: bit0 hit enable, bit1 miss enable, bit2 hit clear, bit3 miss clear, bit4 error interrupt enable, bit5 end interrupt enable.
  - Offset 1 is status, read-only: bit0 error flag, bit1 end flag.
  - Offset 2 is the flag-clear register. It is write-only and reads as 0.
  - Offset 3 is the hit counter, zero-extended.
  - Offset 4 is the miss counter, zero-extended.
  - Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ev_hit | input | 1 | One-cycle pulse: transaction served without a downstream access |
| ev_miss | input | 1 | One-cycle pulse: transaction caused a downstream access |
| ev_wr_err | input | 1 | Unsupported cacheable write detected |
| ev_inval_done | input | 1 | Invalidation sequence finished |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for the register at `bus_addr` |
| irq | output | 1 | Interrupt request from the enabled flags |

## Verification
The hardest condition to reach from the ports is saturation. A 32-bit hit counter cannot be filled in a practical run, so the bench builds the unit with a 6-bit hit counter and a 4-bit miss counter. It then sweeps the event count past each maximum and compares every read with the minimum of the count and the all-ones value. The collisions are also hard to reach: a counter clear meeting an increment, and a flag set meeting a flag clear. The bench holds the event input high across the same cycle as the register write, so both land on one edge.

// File: rtl/cmon_pkg.sv
`timescale 1ns/1ps
package cmon_pkg;

    localparam int ADDR_W = 3;
    localparam int NFLAG  = 2;

    localparam logic [ADDR_W-1:0] OFS_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_FCLR = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_HIT  = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_MISS = 3'd4;

    // control register bit positions
    localparam int B_HIT_EN  = 0;
    localparam int B_MISS_EN = 1;
    localparam int B_HIT_CLR = 2;
    localparam int B_MISS_CLR= 3;
    localparam int B_ERR_IE  = 4;
    localparam int B_END_IE  = 5;

    // flag index order inside flag vectors
    localparam int F_ERR = 0;
    localparam int F_END = 1;

    typedef struct packed {
        logic end_ie;
        logic err_ie;
        logic miss_en;
        logic hit_en;
    } ctrl_t;

    typedef struct packed {
        logic             hit_clr;
        logic             miss_clr;
        logic [NFLAG-1:0] flag_clr;
    } cmd_t;

    function automatic logic addr_hit(input logic wr, input logic [ADDR_W-1:0] a,
                                      input logic [ADDR_W-1:0] ofs);
        return wr && (a == ofs);
    endfunction

endpackage

// File: rtl/cmon_counter.sv
`timescale 1ns/1ps
module cmon_counter #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         en,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    localparam logic [W-1:0] MAXV = '1;

    logic at_max;
    assign at_max = (cnt == MAXV);

    always_ff @(posedge clk) begin
        if (rst)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (en && inc && !at_max)
            cnt <= cnt + W'(1);
    end

    a_r5_clear_zero: assert property (@(posedge clk) disable iff (rst)
        clr |=> (cnt == '0));

    a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt >= $past(cnt)));

    a_r6_hold_when_off: assert property (@(posedge clk) disable iff (rst)
        (!en && !clr) |=> $stable(cnt));

endmodule

// File: rtl/cmon_flags.sv
`timescale 1ns/1ps
module cmon_flags #(
    parameter int N = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] set,
    input  logic [N-1:0] clr,
    input  logic [N-1:0] ie,
    output logic [N-1:0] flags,
    output logic         irq
);
    for (genvar i = 0; i < N; i++) begin : g_flag
        always_ff @(posedge clk) begin
            if (rst)
                flags[i] <= 1'b0;
            else
                flags[i] <= set[i] | (flags[i] & ~clr[i]);
        end

        a_r7_sticky: assert property (@(posedge clk) disable iff (rst)
            (flags[i] && !clr[i]) |=> flags[i]);

        a_r8_set_wins: assert property (@(posedge clk) disable iff (rst)
            set[i] |=> flags[i]);
    end

    assign irq = |(flags & ie);

    a_r9_irq_cause: assert property (@(posedge clk) disable iff (rst)
        irq |-> (|flags));

endmodule

// File: rtl/cmon_regs.sv
`timescale 1ns/1ps
module cmon_regs
    import cmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HIT_W  = 32,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [HIT_W-1:0]  hit_cnt,
    input  logic [MISS_W-1:0] miss_cnt,
    input  logic [NFLAG-1:0]  flags,
    output ctrl_t             ctrl,
    output cmd_t              cmd,
    output logic [DATA_W-1:0] bus_rdata
);
    logic wr_ctrl, wr_fclr;
    assign wr_ctrl = addr_hit(bus_wr, bus_addr, OFS_CTRL);
    assign wr_fclr = addr_hit(bus_wr, bus_addr, OFS_FCLR);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl <= '0;
        end else if (wr_ctrl) begin
            ctrl.hit_en  <= bus_wdata[B_HIT_EN];
            ctrl.miss_en <= bus_wdata[B_MISS_EN];
            ctrl.err_ie  <= bus_wdata[B_ERR_IE];
            ctrl.end_ie  <= bus_wdata[B_END_IE];
        end
    end

    // clear strobes live for the write cycle only
    always_comb begin
        cmd.hit_clr  = wr_ctrl && bus_wdata[B_HIT_CLR];
        cmd.miss_clr = wr_ctrl && bus_wdata[B_MISS_CLR];
        cmd.flag_clr = wr_fclr ? bus_wdata[NFLAG-1:0] : '0;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CTRL: begin
                bus_rdata[B_HIT_EN]  = ctrl.hit_en;
                bus_rdata[B_MISS_EN] = ctrl.miss_en;
                bus_rdata[B_ERR_IE]  = ctrl.err_ie;
                bus_rdata[B_END_IE]  = ctrl.end_ie;
            end
            OFS_STAT: bus_rdata[NFLAG-1:0] = flags;
            OFS_HIT:  bus_rdata = DATA_W'(hit_cnt);
            OFS_MISS: bus_rdata = DATA_W'(miss_cnt);
            default:  bus_rdata = '0;
        endcase
    end

    a_r5_clr_no_enable_change: assert property (@(posedge clk) disable iff (rst)
        !wr_ctrl |=> $stable(ctrl));

endmodule

// File: rtl/cache_mon.sv
`timescale 1ns/1ps
module cache_mon
    import cmon_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int HIT_W  = 32,
    parameter int MISS_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ev_hit,
    input  logic              ev_miss,
    input  logic              ev_wr_err,
    input  logic              ev_inval_done,
    input  logic              bus_wr,
    input  logic [2:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    ctrl_t             ctrl;
    cmd_t              cmd;
    logic [HIT_W-1:0]  hit_cnt;
    logic [MISS_W-1:0] miss_cnt;
    logic [NFLAG-1:0]  flags, fset, fie;

    cmon_regs #(.DATA_W(DATA_W), .HIT_W(HIT_W), .MISS_W(MISS_W)) regs_i (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .hit_cnt(hit_cnt), .miss_cnt(miss_cnt),
        .flags(flags), .ctrl(ctrl), .cmd(cmd), .bus_rdata(bus_rdata)
    );

    cmon_counter #(.W(HIT_W)) hit_i (
        .clk(clk), .rst(rst), .en(ctrl.hit_en), .clr(cmd.hit_clr),
        .inc(ev_hit), .cnt(hit_cnt)
    );

    cmon_counter #(.W(MISS_W)) miss_i (
        .clk(clk), .rst(rst), .en(ctrl.miss_en), .clr(cmd.miss_clr),
        .inc(ev_miss), .cnt(miss_cnt)
    );

    always_comb begin
        fset        = '0;
        fset[F_ERR] = ev_wr_err;
        fset[F_END] = ev_inval_done;
        fie         = '0;
        fie[F_ERR]  = ctrl.err_ie;
        fie[F_END]  = ctrl.end_ie;
    end

    cmon_flags #(.N(NFLAG)) flags_i (
        .clk(clk), .rst(rst), .set(fset), .clr(cmd.flag_clr), .ie(fie),
        .flags(flags), .irq(irq)
    );

    a_r1_hit_step: assert property (@(posedge clk) disable iff (rst)
        (!cmd.hit_clr) |=> (hit_cnt - $past(hit_cnt) <= HIT_W'(1)));

    a_r2_miss_step: assert property (@(posedge clk) disable iff (rst)
        (!cmd.miss_clr) |=> (miss_cnt - $past(miss_cnt) <= MISS_W'(1)));

endmodule

// File: tb/cache_mon_tb_top.sv
`timescale 1ns/1ps
module cache_mon_tb_top;
    localparam int DW = 32;
    localparam int HW = 6;
    localparam int MW = 4;
    localparam int HMAX = (1 << HW) - 1;
    localparam int MMAX = (1 << MW) - 1;

    logic clk = 0, rst = 1;
    logic ev_hit = 0, ev_miss = 0, ev_wr_err = 0, ev_inval_done = 0;
    logic bus_wr = 0;
    logic [2:0] bus_addr = 0;
    logic [DW-1:0] bus_wdata = 0;
    logic [DW-1:0] bus_rdata;
    logic irq;

    int total = 0, bad = 0;

    always #10 clk = ~clk;

    cache_mon #(.DATA_W(DW), .HIT_W(HW), .MISS_W(MW)) dut_i (
        .clk(clk), .rst(rst), .ev_hit(ev_hit), .ev_miss(ev_miss),
        .ev_wr_err(ev_wr_err), .ev_inval_done(ev_inval_done),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    task automatic check(input string req, input longint got, input longint exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
        end
    endtask

    task automatic rd(input logic [2:0] a, output logic [DW-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [2:0] a, input logic [DW-1:0] d);
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 0; bus_wdata = 0;
    endtask

    task automatic ev(input logic h, input logic m, input logic e, input logic d);
        ev_hit = h; ev_miss = m; ev_wr_err = e; ev_inval_done = d;
        @(negedge clk);
        ev_hit = 0; ev_miss = 0; ev_wr_err = 0; ev_inval_done = 0;
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        total++; bad++;
        $display("FAIL watchdog: got=1 expected=0");
        finish_run();
    end

    initial begin
        logic [DW-1:0] d;
        repeat (3) @(negedge clk);
        rst = 0;

        // R3 reset state
        rd(3'd0, d); check("R3 ctrl", d, 0);
        rd(3'd1, d); check("R3 status", d, 0);
        rd(3'd3, d); check("R3 hit", d, 0);
        rd(3'd4, d); check("R3 miss", d, 0);
        check("R3 irq", irq, 0);
        rd(3'd2, d); check("R10 fclr reads 0", d, 0);
        rd(3'd7, d); check("R10 unmapped", d, 0);

        // R6 disabled counters ignore events
        for (int i = 0; i < 3; i++) ev(1, 1, 0, 0);
        rd(3'd3, d); check("R6 hit off", d, 0);
        rd(3'd4, d); check("R6 miss off", d, 0);

        // R1 / R4 hit sweep past saturation, miss disabled
        wr(3'd0, 32'h1);
        for (int k = 1; k <= HMAX + 8; k++) begin
            ev(1, 1, 0, 0);
            rd(3'd3, d); check("R1 R4 hit sweep", d, (k < HMAX) ? k : HMAX);
        end
        rd(3'd4, d); check("R6 miss held", d, 0);

        // R5 clear collides with increment
        ev_hit = 1;
        wr(3'd0, 32'h5);
        ev_hit = 0;
        rd(3'd3, d); check("R5 clear wins", d, 0);
        rd(3'd0, d); check("R5 clr self-clears", d, 1);

        // R2 / R4 miss sweep, hit disabled
        wr(3'd0, 32'h2);
        for (int k = 1; k <= MMAX + 6; k++) begin
            ev(1, 1, 0, 0);
            rd(3'd4, d); check("R2 R4 miss sweep", d, (k < MMAX) ? k : MMAX);
        end
        rd(3'd3, d); check("R6 hit held", d, 0);

        // R2 joint counting after clearing both
        wr(3'd0, 32'hF);
        rd(3'd4, d); check("R5 miss clear", d, 0);
        for (int k = 1; k <= 5; k++) ev(1, 1, 0, 0);
        ev(0, 1, 0, 0);
        rd(3'd3, d); check("R1 joint hit", d, 5);
        rd(3'd4, d); check("R2 joint miss", d, 6);

        // R7 error flag
        ev(0, 0, 1, 0);
        rd(3'd1, d); check("R7 err set", d, 1);
        check("R9 irq masked", irq, 0);
        wr(3'd0, 32'h13);
        check("R9 irq err", irq, 1);
        wr(3'd2, 32'h1);
        rd(3'd1, d); check("R7 err cleared", d, 0);
        check("R9 irq off", irq, 0);

        // R8 end flag
        ev(0, 0, 0, 1);
        rd(3'd1, d); check("R8 end set", d, 2);
        check("R9 end masked", irq, 0);
        wr(3'd0, 32'h23);
        check("R9 irq end", irq, 1);
        ev_inval_done = 1;
        wr(3'd2, 32'h2);
        ev_inval_done = 0;
        rd(3'd1, d); check("R8 set wins", d, 2);
        ev(0, 0, 1, 0);
        wr(3'd2, 32'h1);
        rd(3'd1, d); check("R8 other flag kept", d, 2);
        wr(3'd2, 32'h2);
        rd(3'd1, d); check("R8 end cleared", d, 0);
        check("R9 irq end off", irq, 0);

        finish_run();
    end
endmodule